// File: doc/BRIEF.md
# Iterative Soft Decoder for a 2x2 Product Code

This block recovers four data bits from each packet of a rate-1/2 product code. The code places the data bits in a 2x2 grid and protects every row and every column with an even-parity bit. The block takes soft received values rather than hard bits. Eight signed samples arrive serially, one per clock. A start pulse marks the first sample of each packet. A positive sample leans towards bit 0 and a negative sample leans towards bit 1; a clean symbol sits at +32 or -32.

The block first collects the samples of a packet into a frame register. On the start pulse that opens the next packet, it hands the complete frame to an iteration engine. The engine runs extrinsic-value exchanges, alternating row-parity and column-parity steps with one step per clock. Each step uses the sign-times-minimum rule. The posterior of a data bit is its own sample plus its latest extrinsic value. On the following start pulse the signs of the four posteriors are registered as the decoded bits, and a one-cycle valid pulse marks them.

Top module: `pcode_soft_dec`

## Requirements
- R1: While reset is active, and after it is released until the first emission, `out_valid` is 0 and `data_bits` is 0.
- R2: The sample present on the cycle where `start` is high is slot 0 (data y0). The following seven cycles fill slots 1..7 in the order y1, y2, y3, row parity r0 (row y0,y1), row parity r1 (row y2,y3), column parity c0 (column y0,y2), column parity c1 (column y1,y3). Samples after slot 7 and before the next `start` have no effect on any result.
- R3: Samples of -128 and +127 are processed without wrap-around. Every extrinsic value stays within magnitude 2^(SAMPLE_W-1).
- R4: The combining rule is f(A,B) = sign(A*B) * min(|A|,|B|). A zero operand gives 0.
- R5: A frame is loaded with all extrinsic values at zero. The first step is a row step: y0,y1 pair with r0 and y2,y3 pair with r1, each using its row partner. The next step is a column step: y0,y2 pair with c0 and y1,y3 pair with c1, each using its column partner. Steps alternate, one per clock, with A = partner sample + partner extrinsic. After ITER_STEPS steps the values hold.
- R6: The posterior of bit i is sample i plus extrinsic i. A posterior above 0 decodes to bit 0; zero or below decodes to 1. `data_bits[i]` carries y_i.
- R7: A frame is decoded only if all eight slots arrived before the next `start`. Its bits appear, with `out_valid` high for exactly one cycle, on the cycle after the `start` that follows the one which loaded it. A `start` with no loaded frame emits nothing.
- R8: `data_bits` holds its value on every cycle where `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | High on the cycle carrying slot 0 of a packet |
| rx_sample | input | SAMPLE_W | Received soft sample, two's complement |
| data_bits | output | 4 | Decoded data bits, bit i is y_i |
| out_valid | output | 1 | One-cycle pulse when `data_bits` is updated |

## Verification
The bench builds the block with its defaults: SAMPLE_W = 8, which gives the full -128..+127 sample range, and ITER_STEPS = 6, which gives three row steps and three column steps. With six steps, back-to-back packets of eight cycles finish their iterations before they are emitted. A short packet placed before a full one truncates the iteration count of the frame loaded earlier, which exercises the hold and truncation paths. Long idle gaps filled with junk samples show that the frame register ignores late samples, and that the engine stops after the last step.

// File: rtl/pcd_pkg.sv
// Shared constants and types for the product-code soft decoder.
// Assumes a fixed 2x2 data grid: four data slots followed by two row
// parities and two column parities in the serial order.
package pcd_pkg;
    localparam int unsigned NUM_DATA  = 4;
    localparam int unsigned NUM_SLOTS = 8;
    localparam int unsigned SLOT_ROW0 = 4;   // r0 slot, r1 follows
    localparam int unsigned SLOT_COL0 = 6;   // c0 slot, c1 follows

    typedef enum logic {
        PH_ROW = 1'b0,
        PH_COL = 1'b1
    } phase_e;
endpackage

// File: rtl/pcd_collect.sv
// Serial-to-parallel frame collector.
// Shifts in the start sample and the next SLOTS-1 samples, then freezes
// until the next start. frame_full reports that all slots were taken.
// Assumes start is a single-cycle marker on the first sample.
module pcd_collect #(
    parameter int unsigned SAMPLE_W = 8,
    parameter int unsigned SLOTS    = pcd_pkg::NUM_SLOTS
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [SAMPLE_W-1:0]       rx_sample,
    output logic [SLOTS*SAMPLE_W-1:0] frame_flat,
    output logic                      frame_full
);
    localparam int unsigned CNT_W = $clog2(SLOTS + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(SLOTS);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    logic [CNT_W-1:0]          cnt_q;
    logic [SLOTS*SAMPLE_W-1:0] sr_q;
    logic                      taking;

    // Capture window: start cycle and the slots that follow it.
    assign taking = start || ((cnt_q != '0) && (cnt_q < CNT_FULL));

    // Count samples taken since the last start, saturating at SLOTS.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= CNT_ONE;
        end else if (taking) begin
            cnt_q <= cnt_q + CNT_ONE;
        end
    end

    // Shift new samples in at the top; slot 0 ends at the bottom.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (taking) begin
            sr_q <= {rx_sample, sr_q[SLOTS*SAMPLE_W-1:SAMPLE_W]};
        end
    end

    assign frame_flat = sr_q;
    assign frame_full = (cnt_q == CNT_FULL);
endmodule

// File: rtl/pcd_signmin.sv
// Sign-times-minimum combiner: y = sign(a*b) * min(|a|,|b|).
// Pure combinational. Magnitudes are taken as unsigned W-bit values, so
// the most negative input keeps its magnitude. A zero operand yields 0.
module pcd_signmin #(
    parameter int unsigned W = 10
) (
    input  logic signed [W-1:0] a,
    input  logic signed [W-1:0] b,
    output logic signed [W-1:0] y
);
    logic [W-1:0] mag_a;
    logic [W-1:0] mag_b;
    logic [W-1:0] mag_min;
    logic         neg;

    // Absolute values, compare, and signed result.
    always_comb begin
        mag_a   = a[W-1] ? (~a + 1'b1) : a;
        mag_b   = b[W-1] ? (~b + 1'b1) : b;
        mag_min = (mag_a < mag_b) ? mag_a : mag_b;
        neg     = a[W-1] ^ b[W-1];
        y       = neg ? signed'(~mag_min + 1'b1) : signed'(mag_min);
    end
endmodule

// File: rtl/pcd_iter_engine.sv
// Iteration engine for the 2x2 product code.
// On load it latches a frame and clears the extrinsic values. On each
// following clock it performs one exchange, row first and then column,
// alternating, until ITER_STEPS exchanges are done. Posterior signs are
// available combinationally as decisions (1 when posterior <= 0).
// Assumes SUM_W >= SAMPLE_W + 2 so partner sums never overflow.
module pcd_iter_engine #(
    parameter int unsigned SAMPLE_W   = 8,
    parameter int unsigned SUM_W      = SAMPLE_W + 2,
    parameter int unsigned ITER_STEPS = 6,
    parameter int unsigned SLOTS      = pcd_pkg::NUM_SLOTS,
    parameter int unsigned NDATA      = pcd_pkg::NUM_DATA
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load,
    input  logic [SLOTS*SAMPLE_W-1:0] frame_flat,
    output logic [NDATA*SUM_W-1:0]    ext_flat,
    output logic [NDATA-1:0]          dec_bits
);
    import pcd_pkg::*;

    localparam int unsigned STEP_W = $clog2(ITER_STEPS + 1);
    localparam logic [STEP_W-1:0] STEP_MAX = STEP_W'(ITER_STEPS);
    localparam logic [STEP_W-1:0] STEP_ONE = STEP_W'(1);

    logic [SAMPLE_W-1:0]     pkt_q [SLOTS];
    logic signed [SUM_W-1:0] sw    [SLOTS];
    logic signed [SUM_W-1:0] ext_q [NDATA];
    logic signed [SUM_W-1:0] ext_d [NDATA];
    logic signed [SUM_W-1:0] post  [NDATA];
    logic [STEP_W-1:0]       steps_q;
    phase_e                  phase_q;
    logic                    stepping;

    assign stepping = (steps_q < STEP_MAX);

    // Latch frame slots on load and sign-extend them to the sum width.
    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pkt_q[k] <= '0;
            end else if (load) begin
                pkt_q[k] <= frame_flat[k*SAMPLE_W +: SAMPLE_W];
            end
        end
        assign sw[k] = {{(SUM_W-SAMPLE_W){pkt_q[k][SAMPLE_W-1]}}, pkt_q[k]};
    end

    // Per data bit: choose partner and parity by phase, combine, decide.
    for (genvar i = 0; i < NDATA; i++) begin : g_bit
        localparam int unsigned RP   = i ^ 1;
        localparam int unsigned CP   = i ^ 2;
        localparam int unsigned RPAR = SLOT_ROW0 + (i >> 1);
        localparam int unsigned CPAR = SLOT_COL0 + (i & 1);

        logic signed [SUM_W-1:0] a_in;
        logic signed [SUM_W-1:0] b_in;

        assign a_in = (phase_q == PH_ROW) ? (sw[RP] + ext_q[RP])
                                          : (sw[CP] + ext_q[CP]);
        assign b_in = (phase_q == PH_ROW) ? sw[RPAR] : sw[CPAR];

        pcd_signmin #(.W(SUM_W)) u_sm (
            .a (a_in),
            .b (b_in),
            .y (ext_d[i])
        );

        // Extrinsic register: cleared on load, updated while stepping.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ext_q[i] <= '0;
            end else if (load) begin
                ext_q[i] <= '0;
            end else if (stepping) begin
                ext_q[i] <= ext_d[i];
            end
        end

        assign post[i]     = sw[i] + ext_q[i];
        assign dec_bits[i] = post[i][SUM_W-1] | (post[i] == '0);
        assign ext_flat[i*SUM_W +: SUM_W] = ext_q[i];
    end

    // Step counter and row/column phase sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            steps_q <= '0;
            phase_q <= PH_ROW;
        end else if (load) begin
            steps_q <= '0;
            phase_q <= PH_ROW;
        end else if (stepping) begin
            steps_q <= steps_q + STEP_ONE;
            phase_q <= (phase_q == PH_ROW) ? PH_COL : PH_ROW;
        end
    end
endmodule

// File: rtl/pcode_soft_dec.sv
// Top level of the product-code iterative soft decoder.
// A start with a complete frame behind it loads the engine. A start that
// finds a frame already in the engine first emits that frame's decisions
// with a one-cycle valid pulse. Assumes packets are framed by start only.
module pcode_soft_dec #(
    parameter int unsigned SAMPLE_W   = 8,
    parameter int unsigned ITER_STEPS = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [SAMPLE_W-1:0] rx_sample,
    output logic [3:0]          data_bits,
    output logic                out_valid
);
    localparam int unsigned SLOTS = pcd_pkg::NUM_SLOTS;
    localparam int unsigned NDATA = pcd_pkg::NUM_DATA;
    localparam int unsigned SUM_W = SAMPLE_W + 2;

    logic [SLOTS*SAMPLE_W-1:0] frame_flat;
    logic                      frame_full;
    logic [NDATA*SUM_W-1:0]    ext_flat;
    logic [NDATA-1:0]          dec_bits;
    logic                      load;
    logic                      loaded_q;

    assign load = start && frame_full;

    pcd_collect #(.SAMPLE_W(SAMPLE_W), .SLOTS(SLOTS)) u_collect (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .rx_sample  (rx_sample),
        .frame_flat (frame_flat),
        .frame_full (frame_full)
    );

    pcd_iter_engine #(
        .SAMPLE_W   (SAMPLE_W),
        .SUM_W      (SUM_W),
        .ITER_STEPS (ITER_STEPS),
        .SLOTS      (SLOTS),
        .NDATA      (NDATA)
    ) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .frame_flat (frame_flat),
        .ext_flat   (ext_flat),
        .dec_bits   (dec_bits)
    );

    // Track whether the engine holds a frame awaiting emission.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loaded_q <= 1'b0;
        end else if (start) begin
            loaded_q <= frame_full;
        end
    end

    // Emit decisions of the held frame on start, with a valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_bits <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= start && loaded_q;
            if (start && loaded_q) begin
                data_bits <= dec_bits;
            end
        end
    end
endmodule

// File: rtl/pcd_checker.sv
// Property checker for pcode_soft_dec, attached by bind below.
// Watches the output handshake, the load strobe and the extrinsic values.
module pcd_checker #(
    parameter int unsigned SAMPLE_W = 8,
    parameter int unsigned SUM_W    = SAMPLE_W + 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               out_valid,
    input logic [3:0]         data_bits,
    input logic               load,
    input logic [4*SUM_W-1:0] ext_flat
);
    localparam int LIM = 2 ** (SAMPLE_W - 1);

    logic ext_in_range;

    // Flag that every extrinsic value lies within the sample range.
    always_comb begin
        ext_in_range = 1'b1;
        for (int i = 0; i < 4; i++) begin
            if ($signed(ext_flat[i*SUM_W +: SUM_W]) > LIM ||
                $signed(ext_flat[i*SUM_W +: SUM_W]) < -LIM) begin
                ext_in_range = 1'b0;
            end
        end
    end

    a_r7_valid_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(start));

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    a_r8_bits_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(data_bits));

    a_r3_ext_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        ext_in_range);

    a_r5_ext_cleared_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        $past(load) |-> (ext_flat == '0));
endmodule

bind pcode_soft_dec pcd_checker #(.SAMPLE_W(SAMPLE_W), .SUM_W(SUM_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .out_valid (out_valid),
    .data_bits (data_bits),
    .load      (load),
    .ext_flat  (ext_flat)
);

// File: tb/sim_pcode_soft_dec.sv
// Self-checking bench: directed corner packets plus seeded random ones,
// compared against a behavioural model of the requirements.
module sim_pcode_soft_dec;
    localparam int ITER = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] rx_sample = '0;
    logic [3:0] data_bits;
    logic       out_valid;

    int checks = 0;
    int fails  = 0;

    // Model state
    int    cyc = 0;
    int    cap [8];
    int    cap_cnt = 0;
    bit    have_loaded = 0;
    int    ld_pkt [8];
    int    ld_cyc = 0;
    string ld_tag = "";
    string cap_tag = "";
    bit    expect_next = 0;
    logic [3:0] exp_bits = '0;
    string exp_tag = "";
    logic [3:0] last_bits = '0;

    always #4 clk = ~clk;

    pcode_soft_dec #(.SAMPLE_W(8), .ITER_STEPS(ITER)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .rx_sample (rx_sample),
        .data_bits (data_bits),
        .out_valid (out_valid)
    );

    function automatic int sm(input int a, input int b);
        int ma, mb, m;
        ma = (a < 0) ? -a : a;
        mb = (b < 0) ? -b : b;
        m  = (ma < mb) ? ma : mb;
        return (((a < 0) != (b < 0)) ? -m : m);
    endfunction

    function automatic logic [3:0] model(input int s[8], input int steps);
        int e [4];
        int n [4];
        logic [3:0] r;
        for (int i = 0; i < 4; i++) e[i] = 0;
        for (int k = 0; k < steps; k++) begin
            for (int i = 0; i < 4; i++) begin
                if (k % 2 == 0) n[i] = sm(s[i ^ 1] + e[i ^ 1], s[4 + (i >> 1)]);
                else            n[i] = sm(s[i ^ 2] + e[i ^ 2], s[6 + (i & 1)]);
            end
            for (int i = 0; i < 4; i++) e[i] = n[i];
        end
        for (int i = 0; i < 4; i++) r[i] = ((s[i] + e[i]) <= 0);
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // One cycle: check outputs of the previous edge, then drive inputs.
    task automatic drive(input bit st, input int s);
        @(negedge clk);
        if (expect_next) begin
            check(out_valid === 1'b1, "R7 valid pulse", int'(out_valid), 1);
            check(data_bits === exp_bits, exp_tag, int'(data_bits), int'(exp_bits));
            last_bits = exp_bits;
        end else begin
            check(out_valid === 1'b0, "R7 no pulse", int'(out_valid), 0);
            check(data_bits === last_bits, "R8 hold", int'(data_bits), int'(last_bits));
        end
        expect_next = 0;
        if (st) begin
            if (have_loaded) begin
                int steps;
                steps = cyc - ld_cyc - 1;
                if (steps > ITER) steps = ITER;
                expect_next = 1;
                exp_bits = model(ld_pkt, steps);
                exp_tag = ld_tag;
            end
            have_loaded = (cap_cnt == 8);
            if (have_loaded) begin
                for (int k = 0; k < 8; k++) ld_pkt[k] = cap[k];
                ld_cyc = cyc;
                ld_tag = cap_tag;
            end
            cap[0] = $signed(8'(s));
            cap_cnt = 1;
        end else if (cap_cnt >= 1 && cap_cnt < 8) begin
            cap[cap_cnt] = $signed(8'(s));
            cap_cnt++;
        end
        start = st;
        rx_sample = 8'(s);
        cyc++;
    endtask

    task automatic send_pkt(input int p[8], input int gap, input string tag);
        cap_tag = tag;
        drive(1, p[0]);
        for (int k = 1; k < 8; k++) drive(0, p[k]);
        for (int g = 0; g < gap; g++) drive(0, int'($urandom() % 256) - 128);
    endtask

    task automatic clean_pkt(input logic [3:0] d, output int p[8]);
        logic [7:0] b;
        b = {d[1] ^ d[3], d[0] ^ d[2], d[2] ^ d[3], d[0] ^ d[1], d};
        for (int k = 0; k < 8; k++) p[k] = b[k] ? -32 : 32;
    endtask

    initial begin
        #(8ns * 200000);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int p [8];
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        // R1: reset state
        check(out_valid === 1'b0, "R1 valid in reset", int'(out_valid), 0);
        check(data_bits === 4'b0, "R1 bits in reset", int'(data_bits), 0);
        @(negedge clk);
        rst_n = 1'b1;
        drive(0, 5);
        drive(0, -7);

        // R6: noise-free packets decode to their data
        for (int d = 0; d < 16; d++) begin
            clean_pkt(4'(d), p);
            send_pkt(p, 0, "R6 clean decode");
        end
        // R5: weak wrong data sample corrected by iterations
        clean_pkt(4'b1010, p);
        p[0] = -6;
        send_pkt(p, 0, "R5 weak flip corrected");
        clean_pkt(4'b0110, p);
        p[3] = 10; p[5] = 4;
        send_pkt(p, 0, "R5 mixed weak samples");
        // R3: extreme samples
        for (int k = 0; k < 8; k++) p[k] = -128;
        send_pkt(p, 0, "R3 all -128");
        p = '{127, -128, 127, -128, -128, -128, 127, -128};
        send_pkt(p, 0, "R3 mixed extremes");
        // R4: zero operands give zero, zero posterior decodes to 1 (R6)
        for (int k = 0; k < 8; k++) p[k] = 0;
        send_pkt(p, 0, "R4 all zero");
        p = '{0, 20, -20, 0, 15, 0, -9, 30};
        send_pkt(p, 0, "R4 some zero");
        // R2: junk samples in the gap must not reach the frame
        clean_pkt(4'b1001, p);
        send_pkt(p, 12, "R2 junk gap");
        // R7: short packet is dropped; packet before it gets fewer steps
        clean_pkt(4'b0011, p);
        p[1] = -3;
        send_pkt(p, 0, "R7 truncated steps");
        cap_tag = "R7 short dropped";
        drive(1, 40); drive(0, 40); drive(0, -40);
        clean_pkt(4'b1100, p);
        send_pkt(p, 0, "R2 after short");
        // R5: seeded random noisy packets
        for (int n = 0; n < 200; n++) begin
            logic [3:0] d;
            d = 4'($urandom());
            clean_pkt(d, p);
            for (int k = 0; k < 8; k++) p[k] = p[k] + int'($urandom() % 81) - 40;
            send_pkt(p, (n % 7 == 0) ? 3 : 0, "R5 random noisy");
        end
        // Flush the last frame out
        drive(1, 0);
        repeat (10) drive(0, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule